// File: doc/BRIEF.md
# Look-Ahead Power-Save Entry Controller

This block decides when a three-channel LED pattern engine may enter its low-power state and when it must come out of it. Every channel engine presents the already-decoded type of the command it is running, its present PWM value, whether it is enabled, whether it is being loaded, a look-ahead tick count, and two decoded command flags. The block merges these with a global power-save enable and the charge-pump mode. A 32 kHz instruction-cycle strobe drives the decision.

Entry is not based on an idle timer. It is decided on every instruction cycle from the command each channel is running and from how long that channel's PWM will stay at zero. The power-save request is registered. It is re-evaluated on each strobe. When it drops, a one-cycle wake pulse is issued. Program execution on the channels is not affected by this block.

Top module: `ps_lookahead_ctrl`

## Requirements
- R1: After reset `ps_req_o` and `wake_o` are 0. `ps_req_o` changes only on the clock edge that samples `tick_i` high, and it holds its value between strobes whatever the other inputs do.
- R2: If `ps_en_i` is 0 when the strobe is sampled, `ps_req_o` becomes 0.
- R3: If any channel has its `ch_load_i` bit at 1 (enabled or not), `ps_req_o` becomes 0.
- R4: A charge-pump mode of 2'b00 (off) or 2'b01 (automatic) permits entry. The codes 2'b10 and 2'b11 (forced modes) refuse it.
- R5: Command code 0 (wait) qualifies only when the PWM is zero and the tick count is strictly greater than THRESH (default 1638).
- R6: Command code 1 (ramp) qualifies only when `ch_tgt_zero_i` is 1 (the ramp ends at zero) and the tick count is at least THRESH. The present PWM value is not considered.
- R7: Command code 2 (trigger wait) qualifies only when the PWM is zero.
- R8: Command code 3 (end) qualifies when the PWM is zero or `ch_end_rst_i` is 1.
- R9: Command code 4 (set) qualifies only when `ch_tgt_zero_i` is 1 and the tick count (the wait of the following command) is at least THRESH.
- R10: Command codes 5, 6 and 7 never qualify.
- R11: A channel with `ch_en_i` at 0 counts as qualifying. Entry requires all three channels to qualify at the same time.
- R12: `wake_o` is high for exactly one clock, on the edge where `ps_req_o` falls from 1 to 0. At all other times it is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | Instruction-cycle strobe (32 kHz rate), one clock wide |
| ps_en_i | input | 1 | Global power-save enable |
| cp_mode_i | input | 2 | Charge-pump mode: 00 off, 01 automatic, 10/11 forced |
| ch_en_i | input | 3 | Per-channel enable |
| ch_load_i | input | 3 | Per-channel load-mode flag |
| ch_cmd_i | input | 9 | Per-channel command code, 3 bits each, channel 0 in the low bits |
| ch_pwm_i | input | 24 | Per-channel PWM value, 8 bits each |
| ch_ticks_i | input | 48 | Per-channel look-ahead tick count, 16 bits each |
| ch_tgt_zero_i | input | 3 | Per-channel flag: the ramp or set target is zero |
| ch_end_rst_i | input | 3 | Per-channel flag: the end command's reset bit |
| ps_req_o | output | 1 | Registered power-save request |
| wake_o | output | 1 | One-clock wake pulse |

## Verification
Both outputs come from one register stage that loads only on the strobe. For every vector the bench therefore changes the inputs and raises `tick_i` at a falling edge. It lowers the strobe at the next falling edge and reads `ps_req_o` and `wake_o` there, one clock edge later. The expected wake value is computed from the previous and the new expected request. To check the hold behaviour, the bench changes the inputs with no strobe, waits several clocks, and confirms that both outputs have not moved.

// File: rtl/ps_pkg.sv
package ps_pkg;
  localparam int CMD_W = 3;

  typedef enum logic [CMD_W-1:0] {
    CMD_WAIT = 3'd0,
    CMD_RAMP = 3'd1,
    CMD_TRIG = 3'd2,
    CMD_END  = 3'd3,
    CMD_SET  = 3'd4
  } cmd_e;

  localparam logic [1:0] CP_OFF  = 2'b00;
  localparam logic [1:0] CP_AUTO = 2'b01;
endpackage

// File: rtl/ps_chan_qual.sv
module ps_chan_qual
  import ps_pkg::*;
#(
  parameter int PW     = 8,
  parameter int TW     = 16,
  parameter int THRESH = 1638
) (
  input  logic [CMD_W-1:0] cmd_i,
  input  logic [PW-1:0]    pwm_i,
  input  logic [TW-1:0]    ticks_i,
  input  logic             en_i,
  input  logic             tgt_zero_i,
  input  logic             end_rst_i,
  output logic             ok_o
);
  localparam logic [TW-1:0] THR = TW'(THRESH);

  logic pwm_zero;
  logic cmd_ok;

  assign pwm_zero = (pwm_i == '0);

  always_comb begin
    case (cmd_e'(cmd_i))
      CMD_WAIT: cmd_ok = pwm_zero && (ticks_i > THR);
      CMD_RAMP: cmd_ok = tgt_zero_i && (ticks_i >= THR);
      CMD_TRIG: cmd_ok = pwm_zero;
      CMD_END:  cmd_ok = pwm_zero || end_rst_i;
      CMD_SET:  cmd_ok = tgt_zero_i && (ticks_i >= THR);
      default:  cmd_ok = 1'b0;
    endcase
  end

  // disabled channel never blocks entry
  assign ok_o = !en_i || cmd_ok;
endmodule

// File: rtl/ps_gate.sv
module ps_gate
  import ps_pkg::*;
#(
  parameter int NCH = 3
) (
  input  logic [NCH-1:0] ch_ok_i,
  input  logic [NCH-1:0] ch_load_i,
  input  logic           ps_en_i,
  input  logic [1:0]     cp_mode_i,
  output logic           allow_o
);
  logic cp_ok;

  assign cp_ok   = (cp_mode_i == CP_OFF) || (cp_mode_i == CP_AUTO);
  assign allow_o = ps_en_i && cp_ok && !(|ch_load_i) && (&ch_ok_i);
endmodule

// File: rtl/ps_state.sv
module ps_state (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tick_i,
  input  logic allow_i,
  output logic ps_req_o,
  output logic wake_o
);
  logic ps_q, wake_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ps_q   <= 1'b0;
      wake_q <= 1'b0;
    end else if (tick_i) begin
      ps_q   <= allow_i;
      wake_q <= ps_q && !allow_i;
    end else begin
      wake_q <= 1'b0;
    end
  end

  assign ps_req_o = ps_q;
  assign wake_o   = wake_q;
endmodule

// File: rtl/ps_lookahead_ctrl.sv
module ps_lookahead_ctrl
  import ps_pkg::*;
#(
  parameter int NCH    = 3,
  parameter int PW     = 8,
  parameter int TW     = 16,
  parameter int THRESH = 1638
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 tick_i,
  input  logic                 ps_en_i,
  input  logic [1:0]           cp_mode_i,
  input  logic [NCH-1:0]       ch_en_i,
  input  logic [NCH-1:0]       ch_load_i,
  input  logic [NCH*CMD_W-1:0] ch_cmd_i,
  input  logic [NCH*PW-1:0]    ch_pwm_i,
  input  logic [NCH*TW-1:0]    ch_ticks_i,
  input  logic [NCH-1:0]       ch_tgt_zero_i,
  input  logic [NCH-1:0]       ch_end_rst_i,
  output logic                 ps_req_o,
  output logic                 wake_o
);
  logic [NCH-1:0] ch_ok;
  logic           allow;

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    ps_chan_qual #(.PW(PW), .TW(TW), .THRESH(THRESH)) u_qual (
      .cmd_i      (ch_cmd_i[c*CMD_W +: CMD_W]),
      .pwm_i      (ch_pwm_i[c*PW +: PW]),
      .ticks_i    (ch_ticks_i[c*TW +: TW]),
      .en_i       (ch_en_i[c]),
      .tgt_zero_i (ch_tgt_zero_i[c]),
      .end_rst_i  (ch_end_rst_i[c]),
      .ok_o       (ch_ok[c])
    );
  end

  ps_gate #(.NCH(NCH)) u_gate (
    .ch_ok_i   (ch_ok),
    .ch_load_i (ch_load_i),
    .ps_en_i   (ps_en_i),
    .cp_mode_i (cp_mode_i),
    .allow_o   (allow)
  );

  ps_state u_state (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .tick_i   (tick_i),
    .allow_i  (allow),
    .ps_req_o (ps_req_o),
    .wake_o   (wake_o)
  );
endmodule

// File: rtl/ps_lookahead_chk.sv
module ps_lookahead_chk #(
  parameter int NCH = 3
) (
  input logic           clk_i,
  input logic           rst_ni,
  input logic           tick_i,
  input logic           ps_en_i,
  input logic [1:0]     cp_mode_i,
  input logic [NCH-1:0] ch_load_i,
  input logic           ps_req_o,
  input logic           wake_o
);
  assert_hold_between_ticks_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tick_i |=> $stable(ps_req_o));

  assert_disabled_refuses_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && !ps_en_i) |=> !ps_req_o);

  assert_load_blocks_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && (|ch_load_i)) |=> !ps_req_o);

  assert_cp_forced_refuses_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && cp_mode_i[1]) |=> !ps_req_o);

  assert_wake_on_fall_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wake_o |-> (!ps_req_o && $past(ps_req_o)));

  assert_wake_single_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wake_o |=> !wake_o);
endmodule

bind ps_lookahead_ctrl ps_lookahead_chk #(.NCH(NCH)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .tick_i    (tick_i),
  .ps_en_i   (ps_en_i),
  .cp_mode_i (cp_mode_i),
  .ch_load_i (ch_load_i),
  .ps_req_o  (ps_req_o),
  .wake_o    (wake_o)
);

// File: tb/sim_ps_lookahead_ctrl.sv
`timescale 1ns/1ps
module sim_ps_lookahead_ctrl;
  localparam int THR = 1638;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick = 1'b0;
  logic        ps_en = 1'b0;
  logic [1:0]  cp = 2'b00;
  logic [2:0]  en = '0, load = '0, tz = '0, er = '0;
  logic [8:0]  cmd = '0;
  logic [23:0] pwm = '0;
  logic [47:0] tk = '0;
  logic        ps_req, wake;

  int n_vec = 0, n_bad = 0;
  bit exp_ps = 1'b0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  ps_lookahead_ctrl u0 (
    .clk_i(clk), .rst_ni(rst_n), .tick_i(tick), .ps_en_i(ps_en), .cp_mode_i(cp),
    .ch_en_i(en), .ch_load_i(load), .ch_cmd_i(cmd), .ch_pwm_i(pwm),
    .ch_ticks_i(tk), .ch_tgt_zero_i(tz), .ch_end_rst_i(er),
    .ps_req_o(ps_req), .wake_o(wake)
  );

  function automatic bit ch_ok(input int c);
    logic [2:0]  cc = cmd[c*3 +: 3];
    logic [7:0]  p  = pwm[c*8 +: 8];
    logic [15:0] t  = tk[c*16 +: 16];
    if (!en[c]) return 1'b1;                 // R11
    case (cc)
      3'd0: return (p == 0) && (t > THR);    // R5
      3'd1: return tz[c] && (t >= THR);      // R6
      3'd2: return (p == 0);                 // R7
      3'd3: return (p == 0) || er[c];        // R8
      3'd4: return tz[c] && (t >= THR);      // R9
      default: return 1'b0;                  // R10
    endcase
  endfunction

  function automatic bit model();
    return ps_en && (load == 0) && (cp < 2) && ch_ok(0) && ch_ok(1) && ch_ok(2);
  endfunction

  task automatic chk(input string tag, input bit act, input bit exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %0b expected %0b", tag, act, exp);
    end
  endtask

  task automatic step(input string tag);
    bit nxt = model();
    bit ew  = exp_ps && !nxt;
    @(negedge clk) tick = 1'b1;
    @(negedge clk) tick = 1'b0;
    chk(tag, ps_req, nxt);
    chk("R12 wake", wake, ew);
    exp_ps = nxt;
  endtask

  function automatic string cmd_tag(input int c);
    case (c)
      0: return "R5";
      1: return "R6";
      2: return "R7";
      3: return "R8";
      4: return "R9";
      default: return "R10";
    endcase
  endfunction

  initial begin
    #200000;
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 reset ps", ps_req, 1'b0);
    chk("R1 reset wake", wake, 1'b0);
    rst_n = 1'b1;
    @(negedge clk);

    // R1: hold without strobe
    ps_en = 1; cp = 2'b01; en = 3'b111; cmd = {3'd2, 3'd2, 3'd2}; pwm = '0;
    step("R1 enter");
    load = 3'b010; pwm = 24'hFFFFFF; cp = 2'b11;
    repeat (4) @(negedge clk);
    chk("R1 hold ps", ps_req, exp_ps);
    chk("R1 hold wake", wake, 1'b0);
    step("R3 leave");

    // per-command sweep on channel 0, others disabled
    ps_en = 1; cp = 2'b00; load = 0; en = 3'b001;
    for (int c = 0; c < 8; c++)
      for (int p = 0; p < 2; p++)
        for (int t = 0; t < 3; t++)
          for (int z = 0; z < 2; z++)
            for (int r = 0; r < 2; r++) begin
              cmd[2:0] = 3'(c); pwm[7:0] = p ? 8'd5 : 8'd0;
              tk[15:0] = 16'(THR - 1 + t); tz[0] = z[0]; er[0] = r[0];
              step(cmd_tag(c));
              // toggle through a qualifying state so falls and wakes recur
              if (c == 0) begin
                cmd[2:0] = 3'd2; pwm[7:0] = 0;
                step("R7 rearm");
              end
            end

    // global gating sweep, all channels on trigger wait with zero PWM
    cmd = {3'd2, 3'd2, 3'd2}; pwm = '0; tz = 0; er = 0;
    for (int e = 0; e < 2; e++)
      for (int m = 0; m < 4; m++)
        for (int l = 0; l < 8; l++)
          for (int n = 0; n < 8; n++) begin
            ps_en = e[0]; cp = 2'(m); load = 3'(l); en = 3'(n);
            if (!ps_en) step("R2");
            else if (load != 0) step("R3");
            else if (cp >= 2) step("R4");
            else step("R11");
          end

    // mixed channels, pseudo-random fields
    ps_en = 1; load = 0;
    for (int i = 0; i < 600; i++) begin
      cp = ($urandom % 4 == 0) ? 2'(2 + $urandom % 2) : 2'($urandom % 2);
      for (int c = 0; c < 3; c++) begin
        en[c] = ($urandom % 4) != 0;
        cmd[c*3 +: 3] = ($urandom % 3 == 0) ? 3'($urandom % 8) : 3'd2;
        pwm[c*8 +: 8] = ($urandom % 3 == 0) ? 8'($urandom) : 8'd0;
        tk[c*16 +: 16] = 16'(THR - 2 + $urandom % 5);
        tz[c] = $urandom % 2; er[c] = $urandom % 2;
      end
      step("R11 mix");
    end

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule